// File: doc/BRIEF.md
# LIN Transmit Fault and Contention Monitor

This block sits between a microcontroller's serial port and the driver stage of a LIN physical layer. It watches the transmit bit the controller commands and the level the bus receiver reports. From these it decides whether the bus driver may follow the transmit bit. It also drives an active-low fault indication. Three conditions count as a fault. The first is a mismatch in which the node commands dominant (0) while the bus stays recessive (1), for example a bus shorted to battery. The second is a thermal shutdown flag. The third is a supply-not-good flag. The analog comparators and the temperature sensor are outside the block and deliver their results as digital flags.

On a real device the fault output and the transmit-enable input share one open-drain pin. Here they are split into a fault output and an external-enable input. An outside agent can pull the enable low to silence the driver, and that is not reported as a fault. Bus propagation delay would otherwise cause false faults after every dominant edge. To prevent this, the mismatch comparison is masked for a programmable number of clock cycles after each falling edge of the effective transmit bit. The default count corresponds to about 25 µs at 100 MHz. The transmit, receive and enable inputs each pass through a two-flop synchronizer before any logic uses them.

Top module: `lin_fault_monitor`

## Requirements
- R1: After synchronous reset, with transmit, receive and enable inputs high and thermal low, fault_n_o is 1, drv_o is 1, contention_o is 0 and overload_o is 0.
- R2: With no fault and the enable high, drv_o equals the transmit input as it stood two clock edges earlier (two-flop synchronizer latency). drv_o is 0 for dominant and 1 for recessive.
- R3: While the synchronized external enable is 0, drv_o is 1. Under that condition a dominant transmit bit against a recessive bus raises no fault, so fault_n_o stays 1.
- R4: While thermal_i is 1, fault_n_o is 0 and drv_o is 1 in the same cycle. When thermal_i returns to 0 and no other fault is present, fault_n_o returns to 1 in the same cycle.
- R5: While vreg_ok_i is 0, fault_n_o is 0, drv_o is 1, and the transmit bit is treated as recessive (1). Consequently overload_o is 0, and no mismatch fault is stored.
- R6: When the synchronized transmit bit is 0 and the synchronized bus is 1 outside the blanking window, with enable 1, thermal 0 and supply good, a mismatch fault is stored at the next edge. From then on fault_n_o is 0 and drv_o is 1.
- R7: A falling edge of the effective transmit bit opens a blanking window covering that cycle and the next BLANK_CYCLES cycles. No mismatch fault is stored inside the window.
- R8: A stored mismatch fault clears at the first edge where both the synchronized transmit bit and the synchronized bus are 1. It holds otherwise, even when the enable drops.
- R9: contention_o is 1 exactly when the synchronized bus is 0 while the effective transmit bit is 1. overload_o is 1 exactly when the synchronized bus is 1 while the effective transmit bit is 0. Contention alone raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| txd_i | input | 1 | Transmit bit from the controller, asynchronous, 0 is dominant |
| rxd_i | input | 1 | Bus level from the receiver comparator, asynchronous |
| ext_en_i | input | 1 | External transmit enable, asynchronous, low silences the driver |
| thermal_i | input | 1 | Thermal shutdown flag, synchronous to clk |
| vreg_ok_i | input | 1 | Regulator output above threshold, synchronous to clk |
| fault_n_o | output | 1 | Active-low fault indication, 0 pulls the shared line |
| drv_o | output | 1 | Gated driver command, 1 is recessive |
| contention_o | output | 1 | Diagnostic: bus dominant while transmitting recessive |
| overload_o | output | 1 | Diagnostic: bus recessive while transmitting dominant |

## Verification
The interesting overlap is a stored mismatch fault meeting a level-driven condition in the same cycle. One case is the thermal flag falling while the bus is still held recessive against a dominant transmit bit. Another is a new transmit falling edge arriving just as the previous blanking window runs out. The bench provokes both by holding input values for random run lengths around the window size and by a directed sequence that keeps the bus high through and past the window. A cycle-by-cycle reference model in the bench predicts every output, so a wrong choice of which fault owns the line in that cycle appears as a miscompare on fault_n_o or drv_o.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

    typedef struct packed {
        logic tx;
        logic rx;
        logic en;
    } lin_pins_t;

    localparam int PINS_W = $bits(lin_pins_t);

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_MISMATCH = 2'd1,
        CAUSE_THERMAL  = 2'd2,
        CAUSE_SUPPLY   = 2'd3
    } fault_cause_e;

    // a weak supply forces the transmit bit recessive
    function automatic logic effective_tx(input logic tx, input logic supply_ok);
        return tx | ~supply_ok;
    endfunction

    function automatic logic bus_held_high(input logic tx, input logic rx);
        return ~tx & rx;
    endfunction

    function automatic logic bus_pulled_low(input logic tx, input logic rx);
        return tx & ~rx;
    endfunction

endpackage

// File: rtl/lfm_sync.sv
module lfm_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lfm_blank.sv
module lfm_blank #(
    parameter int BLANK_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_eff,
    output logic blank
);
    localparam int CW = $clog2(BLANK_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BLANK_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          tx_prev_q;
    logic          fall;

    assign fall  = tx_prev_q & ~tx_eff;
    assign blank = fall | (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_prev_q <= 1'b1;
            cnt_q     <= '0;
        end else begin
            tx_prev_q <= tx_eff;
            if (fall)
                cnt_q <= LOAD;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/lfm_mismatch.sv
module lfm_mismatch
    import lfm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_eff,
    input  logic rx,
    input  logic check_en,
    input  logic blank,
    output logic mis_q
);
    logic set_c;
    logic clr_c;

    assign set_c = check_en & ~blank & bus_held_high(tx_eff, rx);
    assign clr_c = tx_eff & rx;

    always_ff @(posedge clk) begin
        if (rst)        mis_q <= 1'b0;
        else if (set_c) mis_q <= 1'b1;
        else if (clr_c) mis_q <= 1'b0;
    end
endmodule

// File: rtl/lfm_gate.sv
module lfm_gate
    import lfm_pkg::*;
(
    input  logic tx_eff,
    input  logic rx,
    input  logic en,
    input  logic thermal,
    input  logic supply_ok,
    input  logic mis,
    output logic fault_n,
    output logic drv,
    output logic contention,
    output logic overload
);
    fault_cause_e cause;

    always_comb begin
        if (!supply_ok)   cause = CAUSE_SUPPLY;
        else if (thermal) cause = CAUSE_THERMAL;
        else if (mis)     cause = CAUSE_MISMATCH;
        else              cause = CAUSE_NONE;
    end

    assign fault_n    = (cause == CAUSE_NONE);
    assign drv        = (fault_n && en) ? tx_eff : 1'b1;
    assign contention = bus_pulled_low(tx_eff, rx);
    assign overload   = bus_held_high(tx_eff, rx);
endmodule

// File: rtl/lin_fault_monitor.sv
module lin_fault_monitor
    import lfm_pkg::*;
#(
    parameter int BLANK_CYCLES = 2500,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic txd_i,
    input  logic rxd_i,
    input  logic ext_en_i,
    input  logic thermal_i,
    input  logic vreg_ok_i,
    output logic fault_n_o,
    output logic drv_o,
    output logic contention_o,
    output logic overload_o
);
    lin_pins_t raw;
    lin_pins_t synced;
    logic      tx_eff;
    logic      blank_w;
    logic      mis_w;
    logic      check_en;

    assign raw.tx = txd_i;
    assign raw.rx = rxd_i;
    assign raw.en = ext_en_i;

    lfm_sync #(
        .W      (PINS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw),
        .q  (synced)
    );

    assign tx_eff   = effective_tx(synced.tx, vreg_ok_i);
    assign check_en = synced.en & ~thermal_i;

    lfm_blank #(
        .BLANK_CYCLES(BLANK_CYCLES)
    ) u_blank (
        .clk   (clk),
        .rst   (rst),
        .tx_eff(tx_eff),
        .blank (blank_w)
    );

    lfm_mismatch u_mis (
        .clk     (clk),
        .rst     (rst),
        .tx_eff  (tx_eff),
        .rx      (synced.rx),
        .check_en(check_en),
        .blank   (blank_w),
        .mis_q   (mis_w)
    );

    lfm_gate u_gate (
        .tx_eff    (tx_eff),
        .rx        (synced.rx),
        .en        (synced.en),
        .thermal   (thermal_i),
        .supply_ok (vreg_ok_i),
        .mis       (mis_w),
        .fault_n   (fault_n_o),
        .drv       (drv_o),
        .contention(contention_o),
        .overload  (overload_o)
    );
endmodule

// File: rtl/lfm_checker.sv
module lfm_checker (
    input logic clk,
    input logic rst,
    input logic thermal_i,
    input logic vreg_ok_i,
    input logic fault_n_o,
    input logic drv_o,
    input logic contention_o,
    input logic overload_o,
    input logic blank,
    input logic mis_q
);
    assert_thermal_off_R4: assert property (@(posedge clk) disable iff (rst)
        thermal_i |-> (!fault_n_o && drv_o));

    assert_supply_off_R5: assert property (@(posedge clk) disable iff (rst)
        !vreg_ok_i |-> (!fault_n_o && drv_o && !overload_o));

    assert_dominant_needs_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !drv_o |-> fault_n_o);

    assert_no_latch_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mis_q) |-> !$past(blank));

    assert_diag_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({contention_o, overload_o}));
endmodule

bind lin_fault_monitor lfm_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .thermal_i   (thermal_i),
    .vreg_ok_i   (vreg_ok_i),
    .fault_n_o   (fault_n_o),
    .drv_o       (drv_o),
    .contention_o(contention_o),
    .overload_o  (overload_o),
    .blank       (blank_w),
    .mis_q       (mis_w)
);

// File: tb/tb_lin_fault_monitor.sv
module tb_lin_fault_monitor;
    localparam int B = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txd = 1'b1, rxd = 1'b1, en = 1'b1, th = 1'b0, vok = 1'b1;
    logic fault_n, drv, cont, ovl;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic m_tx1, m_tx2, m_rx1, m_rx2, m_en1, m_en2, m_prev, m_mis;
    int   m_cnt;

    always #5 clk = ~clk;

    lin_fault_monitor #(.BLANK_CYCLES(B), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .txd_i(txd), .rxd_i(rxd), .ext_en_i(en),
        .thermal_i(th), .vreg_ok_i(vok), .fault_n_o(fault_n), .drv_o(drv),
        .contention_o(cont), .overload_o(ovl)
    );

    function automatic logic eff_tx();
        return m_tx2 | ~vok;
    endfunction

    task automatic model_edge();
        logic te, fall, blank, set_c, clr_c;
        if (rst) begin
            {m_tx1, m_tx2, m_rx1, m_rx2, m_en1, m_en2, m_prev} = '1;
            m_mis = 1'b0;
            m_cnt = 0;
        end else begin
            te    = eff_tx();
            fall  = m_prev & ~te;
            blank = fall | (m_cnt != 0);
            set_c = m_en2 & ~th & ~blank & ~te & m_rx2;
            clr_c = te & m_rx2;
            if (set_c) m_mis = 1'b1;
            else if (clr_c) m_mis = 1'b0;
            if (fall) m_cnt = B;
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
            m_prev = te;
            m_tx2 = m_tx1; m_tx1 = txd;
            m_rx2 = m_rx1; m_rx1 = rxd;
            m_en2 = m_en1; m_en1 = en;
        end
    endtask

    task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic r, input logic e,
                        input logic h, input logic v, input string tag);
        logic te, flt, ed, ec, eo;
        @(negedge clk);
        txd = t; rxd = r; en = e; th = h; vok = v;
        @(posedge clk);
        model_edge();
        #2;
        te  = eff_tx();
        flt = th | ~vok | m_mis;
        ed  = (!flt && m_en2) ? te : 1'b1;
        ec  = te & ~m_rx2;
        eo  = ~te & m_rx2;
        cmp(tag, "fault_n", fault_n, ~flt);
        cmp(tag, "drv", drv, ed);
        cmp(tag, "contention", cont, ec);
        cmp(tag, "overload", ovl, eo);
    endtask

    task automatic hold(input int n, input logic t, input logic r, input logic e,
                        input logic h, input logic v, input string tag);
        for (int i = 0; i < n; i++) step(t, r, e, h, v, tag);
    endtask

    initial begin
        #5_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1;
        hold(3, 1, 1, 1, 0, 1, "R1");
        rst = 1'b0;
        hold(3, 1, 1, 1, 0, 1, "R1");
        // R2: driver tracks transmit with two-cycle latency, bus echoing
        for (int i = 0; i < 16; i++) begin
            logic b = (i % 3) == 0;
            step(b, b, 1, 0, 1, "R2");
        end
        hold(4, 1, 1, 1, 0, 1, "R2");
        // R7 then R6: bus stuck recessive under dominant transmit
        hold(B + 2, 0, 1, 1, 0, 1, "R7");
        hold(6, 0, 1, 1, 0, 1, "R6");
        // R8: held while enable drops, cleared on recessive pair
        hold(4, 0, 1, 0, 0, 1, "R8");
        hold(5, 1, 1, 1, 0, 1, "R8");
        // R3: external disable masks mismatch
        hold(B + 10, 0, 1, 0, 0, 1, "R3");
        hold(4, 1, 1, 1, 0, 1, "R3");
        // R4: thermal pulse, then release while mismatch still possible
        hold(5, 1, 1, 1, 1, 1, "R4");
        hold(3, 0, 1, 1, 1, 1, "R4");
        hold(B + 6, 0, 1, 1, 0, 1, "R4");
        hold(4, 1, 1, 1, 0, 1, "R4");
        // R5: weak supply forces recessive and blocks mismatch
        hold(B + 6, 0, 1, 1, 0, 0, "R5");
        hold(4, 1, 1, 1, 0, 1, "R5");
        // R9: contention without fault, and overload diag during window
        hold(6, 1, 0, 1, 0, 1, "R9");
        hold(4, 0, 1, 1, 0, 1, "R9");
        hold(4, 1, 1, 1, 0, 1, "R9");
        // R7: re-trigger the window near its end
        hold(B - 1, 0, 1, 1, 0, 1, "R7");
        hold(1, 1, 1, 1, 0, 1, "R7");
        hold(B + 4, 0, 1, 1, 0, 1, "R7");
        hold(4, 1, 1, 1, 0, 1, "R7");
        // random runs around the window length
        for (int s = 0; s < 400; s++) begin
            int    len = 1 + int'($urandom_range(0, B + 12));
            logic  t = $urandom_range(0, 1) == 1;
            int    sel = int'($urandom_range(0, 3));
            logic  r = (sel < 2) ? t : (sel == 2);
            logic  e = $urandom_range(0, 9) != 0;
            logic  h = $urandom_range(0, 14) == 0;
            logic  v = $urandom_range(0, 14) != 0;
            hold(len, t, r, e, h, v, "R6");
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule